// File: doc/BRIEF.md
# Carry-Select Adder Latency Predictor

This block sits next to a carry-select adder that is split into fixed-width blocks. It looks only at the two operands and reports, in the same cycle that they are presented, how many clock cycles the sum needs to settle. The adder itself is not changed. For every block above the lowest one, the predictor works out whether that block's carry-out still waits on the block below it. It then finds the longest unbroken run of such waiting blocks and maps the run length to a latency code. The map comes from two length parameters, which are chosen to suit the target clock period.

The latency code is available combinationally, so the issuing logic can sample it at the edge that ends the operand cycle. A registered copy is also kept. A small counter drives a wait flag that tells the datapath to hold its operands for the extra cycles. While the counter is busy, new start requests are ignored.

Top module: `adder_latency_predictor`

## Requirements
- R1: Block k (k ≥ 1, 4-bit blocks by default) counts as carry-dependent exactly when its operand nibbles sum to 0xF, so that its carry-out is 0 with carry-in 0 and 1 with carry-in 1. Block 0 never counts, whatever its operands are.
- R2: The run length L is the largest number of consecutive carry-dependent blocks among blocks 1 to 7. The internal threshold flags are monotone: if a run of length j+1 is present, a run of length j is present too.
- R3: `lat_now_o` is 2'b00 (one cycle) for L ≤ 4, 2'b01 (two cycles) for L = 5 or 6, and 2'b10 (three cycles) for L = 7, using the default parameters LEN_TWO=5 and LEN_THREE=7. The code 2'b11 never appears.
- R4: `lat_now_o` is purely combinational from the operands, so it is valid in the same cycle the operands are applied.
- R5: On an accepted start (start_i high while no extra cycles are pending), `lat_reg_o` loads `lat_now_o` at that clock edge. At all other times it holds its value.
- R6: After an accepted start with code n, `wait_o` is high for exactly n consecutive cycles, beginning in the start cycle itself. For code 0 it stays low.
- R7: A start_i that arrives while extra cycles are still pending is ignored. Neither `lat_reg_o` nor the wait sequence changes.
- R8: While rst_n is low, `wait_o` is 0 (when start_i is low) and `lat_reg_o` is 2'b00.
- R9: With A=0xFFFFFFFF, B=0x11111111 the code is 00. With A=0xFFFFFFFF and B equal to 0x11000000, 0x10000001 or 0x00000011 the code is 01. With A=0xFFFFFFFF, B=0x00000001 the code is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operands are valid and a new addition begins |
| opa_i | input | 32 | First addend |
| opb_i | input | 32 | Second addend |
| lat_now_o | output | 2 | Same-cycle extra-cycle code |
| lat_reg_o | output | 2 | Code captured at the last accepted start |
| wait_o | output | 1 | High while the adder result is not yet settled |

## Verification
Some properties are checked by assertions on every cycle: the threshold flags stay monotone, the illegal code never appears, the register captures on an accepted start and holds otherwise, the wait tail is right after a start, and a dependency in block 0 alone never raises the code. Only the bench's scenarios can show that the code matches the true longest run for given operands, including the run-length boundaries at 4/5 and 6/7. The same holds for the exact wait pulse length per code and for a start that arrives mid-pulse being dropped. These are compared against a behavioural nibble-sum model for directed and random operands.

// File: rtl/alp_pkg.sv
package alp_pkg;

    typedef logic [1:0] lat_code_t;

    localparam lat_code_t LAT_ONE   = 2'd0;
    localparam lat_code_t LAT_TWO   = 2'd1;
    localparam lat_code_t LAT_THREE = 2'd2;

    typedef struct packed {
        lat_code_t remain;
        lat_code_t lat;
    } alp_state_t;

endpackage

// File: rtl/alp_dep_stage.sv
module alp_dep_stage #(
    parameter int DATA_W = 32,
    parameter int BLK_W  = 4,
    localparam int NBLK  = DATA_W / BLK_W
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [NBLK-1:0]   dep_o
);

    function automatic logic blk_cout(input logic [BLK_W-1:0] x,
                                      input logic [BLK_W-1:0] y,
                                      input logic             cin);
        logic c;
        c = cin;
        for (int i = 0; i < BLK_W; i++) begin
            c = (x[i] & y[i]) | ((x[i] ^ y[i]) & c);
        end
        return c;
    endfunction

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        logic cand0;
        logic cand1;
        assign cand0    = blk_cout(opa_i[k*BLK_W +: BLK_W], opb_i[k*BLK_W +: BLK_W], 1'b0);
        assign cand1    = blk_cout(opa_i[k*BLK_W +: BLK_W], opb_i[k*BLK_W +: BLK_W], 1'b1);
        assign dep_o[k] = ~cand0 & cand1;
    end

endmodule

// File: rtl/alp_run_stage.sv
module alp_run_stage #(
    parameter int NDEP = 7
) (
    input  logic [NDEP-1:0] dep_i,
    output logic [NDEP-1:0] thr_o
);

    for (genvar j = 1; j <= NDEP; j++) begin : g_len
        logic [NDEP-1:0] hit;
        for (genvar i = 0; i < NDEP; i++) begin : g_pos
            if (i + j <= NDEP) begin : g_in
                assign hit[i] = &dep_i[i +: j];
            end else begin : g_out
                assign hit[i] = 1'b0;
            end
        end
        assign thr_o[j-1] = |hit;
    end

endmodule

// File: rtl/alp_encode.sv
module alp_encode
    import alp_pkg::*;
(
    input  logic      reach_two_i,
    input  logic      reach_three_i,
    output lat_code_t code_o
);

    always_comb begin
        if (reach_three_i) begin
            code_o = LAT_THREE;
        end else if (reach_two_i) begin
            code_o = LAT_TWO;
        end else begin
            code_o = LAT_ONE;
        end
    end

endmodule

// File: rtl/adder_latency_predictor.sv
module adder_latency_predictor
    import alp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BLK_W     = 4,
    parameter int LEN_TWO   = 5,
    parameter int LEN_THREE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [1:0]        lat_now_o,
    output logic [1:0]        lat_reg_o,
    output logic              wait_o
);

    localparam int NBLK = DATA_W / BLK_W;
    localparam int NDEP = NBLK - 1;

    logic [NBLK-1:0] dep_all;
    logic [NDEP-1:0] thr;
    lat_code_t       code;
    alp_state_t      st_d, st_q;
    logic            accept;

    alp_dep_stage #(.DATA_W(DATA_W), .BLK_W(BLK_W)) dep_i (
        .opa_i (opa_i),
        .opb_i (opb_i),
        .dep_o (dep_all)
    );

    alp_run_stage #(.NDEP(NDEP)) run_i (
        .dep_i (dep_all[NBLK-1:1]),
        .thr_o (thr)
    );

    alp_encode enc_i (
        .reach_two_i   (thr[LEN_TWO-1]),
        .reach_three_i (thr[LEN_THREE-1]),
        .code_o        (code)
    );

    always_comb begin
        st_d   = st_q;
        accept = start_i && (st_q.remain == 2'd0);
        if (accept) begin
            st_d.lat    = code;
            st_d.remain = (code == LAT_ONE) ? 2'd0 : code - 2'd1;
        end else if (st_q.remain != 2'd0) begin
            st_d.remain = st_q.remain - 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_now_o = code;
    assign lat_reg_o = st_q.lat;
    assign wait_o    = (st_q.remain != 2'd0) || (accept && code != LAT_ONE);

    for (genvar j = 1; j < NDEP; j++) begin : g_thr_chk
        AST_THR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            thr[j] |-> thr[j-1]); // R2
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lat_now_o != 2'b11); // R3

    AST_BLK0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_all[0] && dep_all[NBLK-1:1] == '0) |-> lat_now_o == LAT_ONE); // R1

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !(st_q.remain != 2'd0)) |=> lat_reg_o == $past(lat_now_o)); // R5

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.remain != 2'd0) |=> $stable(lat_reg_o)); // R7

    AST_WAIT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lat_now_o == LAT_THREE) |=> wait_o); // R6

    AST_WAIT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lat_now_o != LAT_THREE) |=> (!wait_o || start_i)); // R6

endmodule

// File: tb/adder_latency_predictor_tb_top.sv
module adder_latency_predictor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [1:0]  lat_now_o;
    logic [1:0]  lat_reg_o;
    logic        wait_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    adder_latency_predictor dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .lat_now_o (lat_now_o),
        .lat_reg_o (lat_reg_o),
        .wait_o    (wait_o)
    );

    localparam int NV = 11;
    localparam logic [65:0] VEC [NV] = '{
        {32'hFFFFFFFF, 32'h11111111, 2'd0},   // R9
        {32'hFFFFFFFF, 32'h11000000, 2'd1},   // R9
        {32'hFFFFFFFF, 32'h10000001, 2'd1},   // R9
        {32'hFFFFFFFF, 32'h00000011, 2'd1},   // R9
        {32'hFFFFFFFF, 32'h00000001, 2'd2},   // R9
        {32'h55555550, 32'hAAAAAAA0, 2'd2},   // R1 nibbles summing to F
        {32'h0000000F, 32'h00000000, 2'd0},   // R1 block 0 alone
        {32'hFFFF0FFF, 32'h00000000, 2'd0},   // R3 L=4
        {32'hFFFFF0FF, 32'h00000000, 2'd1},   // R3 L=5
        {32'h0FFFFFFF, 32'h00000000, 2'd1},   // R3 L=6
        {32'hFFFFFFF0, 32'h00000000, 2'd2}    // R3 L=7
    };

    function automatic logic [1:0] ref_code(input logic [31:0] a, input logic [31:0] b);
        int run  = 0;
        int best = 0;
        for (int k = 1; k < 8; k++) begin
            if ({1'b0, a[k*4 +: 4]} + {1'b0, b[k*4 +: 4]} == 5'd15) begin
                run++;
                if (run > best) best = run;
            end else begin
                run = 0;
            end
        end
        if (best >= 7) return 2'd2;
        if (best >= 5) return 2'd1;
        return 2'd0;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_add(input logic [31:0] a, input logic [31:0] b, input logic [1:0] exp);
        int pulses;
        @(negedge clk);
        opa_i = a; opb_i = b; start_i = 1'b1;
        #1;
        check(lat_now_o == exp, "R3/R4 same-cycle code", lat_now_o, exp);
        check(wait_o == (exp != 0), "R6 wait in start cycle", wait_o, exp != 0);
        pulses = wait_o;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(lat_reg_o == exp, "R5 captured code", lat_reg_o, exp);
        repeat (3) begin
            pulses += wait_o;
            @(negedge clk);
            #1;
        end
        check(pulses == exp, "R6 wait pulse length", pulses, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] ra, rb;
        repeat (3) @(negedge clk);
        #1;
        check(wait_o == 1'b0, "R8 wait in reset", wait_o, 0);
        check(lat_reg_o == 2'd0, "R8 reg in reset", lat_reg_o, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            do_add(VEC[v][65:34], VEC[v][33:2], VEC[v][1:0]);
        end

        for (int r = 0; r < 300; r++) begin
            ra = $urandom;
            rb = (r % 2 == 0) ? (~ra ^ (32'h1 << ($urandom % 32))) : $urandom;
            if (r % 5 == 0) rb = ~ra;
            do_add(ra, rb, ref_code(ra, rb));
        end

        // R7: start during pending cycles is dropped
        @(negedge clk);
        opa_i = 32'hFFFFFFFF; opb_i = 32'h00000001; start_i = 1'b1;
        @(negedge clk);
        opa_i = 32'h0; opb_i = 32'h0;
        #1;
        check(wait_o == 1'b1, "R7 wait kept while busy", wait_o, 1);
        check(lat_reg_o == 2'd2, "R7 reg before ignored start", lat_reg_o, 2);
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(lat_reg_o == 2'd2, "R7 reg after ignored start", lat_reg_o, 2);
        check(wait_o == 1'b0, "R7 no extra wait", wait_o, 0);

        // R8: reset in the middle of a long operation
        @(negedge clk);
        opa_i = 32'hFFFFFFFF; opb_i = 32'h00000001; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rst_n = 1'b0;
        #1;
        check(wait_o == 1'b0, "R8 wait cleared", wait_o, 0);
        check(lat_reg_o == 2'd0, "R8 reg cleared", lat_reg_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        do_add(32'hFFFFFFFF, 32'h11000000, 2'd1); // R9 after reset

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule